// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block turns single bus-cycle requests from a processor core into pin-level timing on an external bus where the low address byte and the 8-bit data share the same pins. The core presents a cycle kind (opcode fetch, memory read, memory write, port read, port write), a 16-bit address and write data. The block runs the cycle: it puts the low address on the shared pins for the first clock while pulsing the address strobe, then uses the same pins for data while the read or write strobe is low. It then returns the captured read byte together with a one-clock completion pulse.

Between cycles the block grants the bus to another master when asked, and it can park in a halt state in which it runs no cycles. In both states every bus output other than the address strobe is floated through its output enable. Each cycle also shows a two-bit status code and a memory/port select, so external logic can decode the cycle.

Top module: `muxbus_cycle_ctrl`

## Requirements
- R1: While reset is held, all output enables (`ad_oe`, `ahi_oe`, `ctl_oe`), `ale`, `hold_ack` and `req_ready` are low, and no cycle starts.
- R2: In the first clock of every cycle `ale` is high for exactly that clock, `ad_oe` and `ahi_oe` are high, `ad_out` carries address bits 7..0, and both `rd_n` and `wr_n` are high.
- R3: During a cycle `stat` reads 2'b11 for an opcode fetch, 2'b10 for any read, 2'b01 for any write; in the halt state it reads 2'b00.
- R4: `iom` is high for port cycles (`req_kind` 3 = port read, 4 = port write) and low for memory cycles (0 = fetch, 1 = memory read, 2 = memory write; codes 5..7 act as memory read).
- R5: For port cycles the 8-bit port number (address bits 7..0) appears on both `ahi_out` and `ad_out` in the first clock; for memory cycles `ahi_out` carries address bits 15..8.
- R6: For reads `rd_n` is low in the second and third clocks with `ad_oe` low; the byte on `ad_in` at the edge that ends the third clock is returned on `rsp_rdata`.
- R7: For writes `wr_n` is low in the second and third clocks and `ad_oe` is high with `ad_out` equal to the write data for those two clocks, so data is valid when `wr_n` rises.
- R8: An opcode fetch lasts four clocks, every other cycle three; `rsp_done` is high for the one clock after the last clock of the cycle, and `req_ready` is low from the first clock to the last.
- R9: A `hold_in` request is taken only between cycles: a running cycle completes first, then `hold_ack` goes high with all three output enables and `ale` low; one clock after `hold_in` drops, `hold_ack` is low and cycles can start again.
- R10: With `halt_in` high and no hold pending, the idle block enters halt: `stat` is 2'b00, all output enables are low and `req_ready` is low; it returns to idle one clock after `halt_in` drops.
- R11: A hold request wins over a halt request and over a pending cycle request, including while already halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core requests a cycle |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Block can accept a request this clock |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Byte captured by the last read |
| hold_in | input | 1 | Another master asks for the bus |
| hold_ack | output | 1 | Bus released to the other master |
| halt_in | input | 1 | Core asks to park in halt |
| ahi_out | output | 8 | High address byte or port number |
| ahi_oe | output | 1 | Enable for `ahi_out` |
| ad_out | output | 8 | Shared address/data pins, driven value |
| ad_oe | output | 1 | Enable for `ad_out` |
| ad_in | input | 8 | Shared address/data pins, sampled value |
| ale | output | 1 | Address latch strobe |
| stat | output | 2 | Cycle status code |
| iom | output | 1 | High for port cycles, low for memory |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ctl_oe | output | 1 | Enable for `iom`, `rd_n`, `wr_n` |

## Verification
A sequencer in the wrong state shows up at once as a strobe in the wrong clock: `ale` outside the first clock, `rd_n` and `wr_n` low together, or a cycle one clock too long or short, which the monitor sees by the completion pulse of that same cycle. A wrong latched kind or address shows as a bad status code, port mirror or address byte during the first clock, and a wrong capture edge as a mismatched read byte on the completion pulse. An arbitration error shows within one clock of the hold or halt change as an enable still high, an acknowledge missing, or a cycle cut short.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

   typedef enum logic [2:0] {
      K_FETCH = 3'd0,
      K_MRD   = 3'd1,
      K_MWR   = 3'd2,
      K_IORD  = 3'd3,
      K_IOWR  = 3'd4
   } kind_e;

   typedef enum logic [2:0] {
      S_RST, S_IDLE, S_T1, S_T2, S_T3, S_T4, S_HOLD, S_HALT
   } st_e;

   localparam logic [1:0] STAT_HALT  = 2'b00;
   localparam logic [1:0] STAT_WRITE = 2'b01;
   localparam logic [1:0] STAT_READ  = 2'b10;
   localparam logic [1:0] STAT_FETCH = 2'b11;

endpackage

// File: rtl/mbc_req_latch.sv
module mbc_req_latch
   import mbc_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              enter_halt,
   input  logic [2:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              is_io,
   output logic              is_wr,
   output logic              is_fetch,
   output logic [1:0]        stat_q
);
   logic [2:0] kind_q;
   logic       k_io, k_wr, k_fetch;

   always_comb begin
      k_io    = (req_kind == K_IORD) || (req_kind == K_IOWR);
      k_wr    = (req_kind == K_MWR)  || (req_kind == K_IOWR);
      k_fetch = (req_kind == K_FETCH);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q  <= K_MRD;
         addr_q  <= '0;
         wdata_q <= '0;
         stat_q  <= STAT_HALT;
      end else if (accept) begin
         kind_q  <= req_kind;
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         stat_q  <= k_fetch ? STAT_FETCH : (k_wr ? STAT_WRITE : STAT_READ);
      end else if (enter_halt) begin
         stat_q  <= STAT_HALT;
      end
   end

   always_comb begin
      is_io    = (kind_q == K_IORD) || (kind_q == K_IOWR);
      is_wr    = (kind_q == K_MWR)  || (kind_q == K_IOWR);
      is_fetch = (kind_q == K_FETCH);
   end
endmodule

// File: rtl/mbc_seq.sv
module mbc_seq
   import mbc_pkg::*;
#(
   parameter int FETCH_CLKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic hold_in,
   input  logic halt_in,
   input  logic is_fetch,
   output st_e  state,
   output logic req_ready,
   output logic accept,
   output logic enter_halt,
   output logic done_q
);
   localparam bit T4_EN = (FETCH_CLKS == 4);

   st_e  nxt;
   logic last;

   always_comb begin
      req_ready  = (state == S_IDLE) && !hold_in && !halt_in;
      accept     = req_ready && req_valid;
      last       = ((state == S_T3) && !(T4_EN && is_fetch)) || (state == S_T4);
      nxt        = state;
      unique case (state)
         S_RST:  nxt = S_IDLE;
         S_IDLE: begin
            if (hold_in)        nxt = S_HOLD;
            else if (halt_in)   nxt = S_HALT;
            else if (req_valid) nxt = S_T1;
         end
         S_T1:   nxt = S_T2;
         S_T2:   nxt = S_T3;
         S_T3:   nxt = last ? S_IDLE : S_T4;
         S_T4:   nxt = S_IDLE;
         S_HOLD: if (!hold_in) nxt = S_IDLE;
         S_HALT: begin
            if (hold_in)       nxt = S_HOLD;
            else if (!halt_in) nxt = S_IDLE;
         end
         default: nxt = S_IDLE;
      endcase
      enter_halt = (nxt == S_HALT) && (state != S_HALT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_RST;
         done_q <= 1'b0;
      end else begin
         state  <= nxt;
         done_q <= last;
      end
   end
endmodule

// File: rtl/mbc_pins.sv
module mbc_pins
   import mbc_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter bit IO_MIRROR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  st_e               state,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [DATA_W-1:0] wdata_q,
   input  logic              is_io,
   input  logic              is_wr,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] ahi_out,
   output logic              ahi_oe,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic              ale,
   output logic              iom,
   output logic              rd_n,
   output logic              wr_n,
   output logic              ctl_oe,
   output logic              hold_ack,
   output logic [DATA_W-1:0] rsp_rdata
);
   logic active, strobe, owned;

   generate
      if (IO_MIRROR) begin : g_mirror
         assign ahi_out = is_io ? addr_q[DATA_W-1:0] : addr_q[ADDR_W-1:DATA_W];
      end else begin : g_plain
         assign ahi_out = addr_q[ADDR_W-1:DATA_W];
      end
   endgenerate

   always_comb begin
      active   = (state == S_T1) || (state == S_T2) || (state == S_T3) || (state == S_T4);
      strobe   = (state == S_T2) || (state == S_T3);
      owned    = active || (state == S_IDLE);
      ahi_oe   = owned;
      ctl_oe   = owned;
      ale      = (state == S_T1);
      ad_oe    = (state == S_T1) || (strobe && is_wr);
      ad_out   = (state == S_T1) ? addr_q[DATA_W-1:0] : wdata_q;
      rd_n     = !(strobe && !is_wr);
      wr_n     = !(strobe && is_wr);
      iom      = is_io;
      hold_ack = (state == S_HOLD);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         rsp_rdata <= '0;
      else if (state == S_T3 && !is_wr)   rsp_rdata <= ad_in;
   end
endmodule

// File: rtl/muxbus_cycle_ctrl.sv
module muxbus_cycle_ctrl
   import mbc_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int FETCH_CLKS = 4,
   parameter bit IO_MIRROR  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   input  logic              hold_in,
   output logic              hold_ack,
   input  logic              halt_in,
   output logic [DATA_W-1:0] ahi_out,
   output logic              ahi_oe,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   input  logic [DATA_W-1:0] ad_in,
   output logic              ale,
   output logic [1:0]        stat,
   output logic              iom,
   output logic              rd_n,
   output logic              wr_n,
   output logic              ctl_oe
);
   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $fatal(1, "address must be two data bytes wide");
      end
      if (FETCH_CLKS != 3 && FETCH_CLKS != 4) begin : g_bad_fetch
         $fatal(1, "fetch length must be 3 or 4 clocks");
      end
   endgenerate

   st_e               state;
   logic              accept, enter_halt;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              is_io, is_wr, is_fetch;

   mbc_seq #(.FETCH_CLKS(FETCH_CLKS)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hold_in(hold_in),
      .halt_in(halt_in), .is_fetch(is_fetch), .state(state),
      .req_ready(req_ready), .accept(accept), .enter_halt(enter_halt),
      .done_q(rsp_done)
   );

   mbc_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .accept(accept), .enter_halt(enter_halt),
      .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
      .addr_q(addr_q), .wdata_q(wdata_q), .is_io(is_io), .is_wr(is_wr),
      .is_fetch(is_fetch), .stat_q(stat)
   );

   mbc_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IO_MIRROR(IO_MIRROR)) u_pins (
      .clk(clk), .rst_n(rst_n), .state(state), .addr_q(addr_q),
      .wdata_q(wdata_q), .is_io(is_io), .is_wr(is_wr), .ad_in(ad_in),
      .ahi_out(ahi_out), .ahi_oe(ahi_oe), .ad_out(ad_out), .ad_oe(ad_oe),
      .ale(ale), .iom(iom), .rd_n(rd_n), .wr_n(wr_n), .ctl_oe(ctl_oe),
      .hold_ack(hold_ack), .rsp_rdata(rsp_rdata)
   );
endmodule

// File: rtl/muxbus_cycle_ctrl_chk.sv
module muxbus_cycle_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ale,
   input logic       ad_oe,
   input logic       ahi_oe,
   input logic       ctl_oe,
   input logic       rd_n,
   input logic       wr_n,
   input logic       hold_ack,
   input logic       req_ready,
   input logic       rsp_done,
   input logic [1:0] stat
);
   a_r2_ale_owns_bus: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (ad_oe && ahi_oe && rd_n && wr_n));

   a_r2_ale_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);

   a_r6_read_floats_ad: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !ad_oe);

   a_r7_write_drives_ad: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> ad_oe);

   a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_n || wr_n));

   a_r9_hold_floats: assert property (@(posedge clk) disable iff (!rst_n)
      hold_ack |-> (!ad_oe && !ahi_oe && !ctl_oe && !ale && !req_ready));

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   a_r3_strobe_status: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> stat[1]);

   a_r1_reset_float: assert property (@(posedge clk)
      !rst_n |-> (!ad_oe && !ahi_oe && !ctl_oe && !ale));
endmodule

bind muxbus_cycle_ctrl muxbus_cycle_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ale(ale), .ad_oe(ad_oe), .ahi_oe(ahi_oe),
   .ctl_oe(ctl_oe), .rd_n(rd_n), .wr_n(wr_n), .hold_ack(hold_ack),
   .req_ready(req_ready), .rsp_done(rsp_done), .stat(stat)
);

// File: tb/muxbus_cycle_ctrl_tb.sv
module muxbus_cycle_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_kind = 3'd0;
   logic [15:0] req_addr = 16'h0;
   logic [7:0]  req_wdata = 8'h0;
   logic        req_ready, rsp_done, hold_ack;
   logic [7:0]  rsp_rdata, ahi_out, ad_out, ad_in;
   logic        hold_in = 1'b0, halt_in = 1'b0;
   logic        ahi_oe, ad_oe, ale, iom, rd_n, wr_n, ctl_oe;
   logic [1:0]  stat;

   int n_chk = 0, n_bad = 0;

   typedef struct {
      logic [7:0] lo, hi, wdata, rdata;
      logic [1:0] st;
      logic       io, wr;
      int         len;
   } exp_t;
   exp_t exp_q[$];

   logic [7:0] lat_lo = 8'h0;

   always #5 clk = ~clk;

   muxbus_cycle_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .hold_in(hold_in),
      .hold_ack(hold_ack), .halt_in(halt_in), .ahi_out(ahi_out),
      .ahi_oe(ahi_oe), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
      .ale(ale), .stat(stat), .iom(iom), .rd_n(rd_n), .wr_n(wr_n),
      .ctl_oe(ctl_oe)
   );

   // bus responder: returned byte depends on the latched address
   assign ad_in = ahi_out ^ lat_lo ^ 8'hA5;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] respond(input logic [7:0] hi, input logic [7:0] lo);
      return hi ^ lo ^ 8'hA5;
   endfunction

   task automatic issue(input logic [2:0] kind, input logic [15:0] addr,
                        input logic [7:0] wd);
      exp_t e;
      e.io    = (kind == 3'd3) || (kind == 3'd4);
      e.wr    = (kind == 3'd2) || (kind == 3'd4);
      e.lo    = addr[7:0];
      e.hi    = e.io ? addr[7:0] : addr[15:8];
      e.wdata = wd;
      e.rdata = respond(e.hi, e.lo);
      e.st    = (kind == 3'd0) ? 2'b11 : (e.wr ? 2'b01 : 2'b10);
      e.len   = (kind == 3'd0) ? 4 : 3;
      while (!req_ready) @(negedge clk);
      exp_q.push_back(e);
      req_valid = 1'b1; req_kind = kind; req_addr = addr; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic finish_cycle();
      wait (exp_q.size() == 0);
      @(negedge clk);
   endtask

   // monitor
   int         len = 0, nrd = 0, nwr = 0, wok = 1;
   logic       busy = 1'b0, t1ok = 1'b0;
   logic [7:0] c_lo = 0, c_hi = 0, c_wd = 0;
   logic [1:0] c_st = 0;
   logic       c_io = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (ale) begin
            busy = 1'b1; len = 1; nrd = 0; nwr = 0; wok = 1;
            c_lo = ad_out; c_hi = ahi_out; c_st = stat; c_io = iom;
            lat_lo = ad_out;
            t1ok = ad_oe && ahi_oe && ctl_oe && rd_n && wr_n && !req_ready;
         end else if (busy && !rsp_done) begin
            len++;
            if (req_ready) t1ok = 1'b0;
            if (!rd_n) begin nrd++; if (ad_oe) wok = 0; end
            if (!wr_n) begin nwr++; c_wd = ad_out; if (!ad_oe) wok = 0; end
         end
         if (rsp_done) begin
            if (exp_q.size() == 0) chk("R8 unexpected completion", 1, 0);
            else begin
               exp_t e;
               e = exp_q.pop_front();
               chk("R2 first clock enables/strobes", t1ok, 1);
               chk("R2 low address byte", c_lo, e.lo);
               chk("R5 high byte / port mirror", c_hi, e.hi);
               chk("R3 status code", c_st, e.st);
               chk("R4 memory/port select", c_io, e.io);
               chk("R8 cycle length", len, e.len);
               if (e.wr) begin
                  chk("R7 write strobe clocks", nwr, 2);
                  chk("R7 write data on bus", c_wd, e.wdata);
                  chk("R7 no read strobe", nrd, 0);
               end else begin
                  chk("R6 read strobe clocks", nrd, 2);
                  chk("R6 read data returned", rsp_rdata, e.rdata);
                  chk("R6 no write strobe", nwr, 0);
               end
               chk("R6 R7 bus direction", wok, 1);
            end
            busy = 1'b0;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset ad_oe", ad_oe, 0);
      chk("R1 reset ahi_oe", ahi_oe, 0);
      chk("R1 reset ctl_oe", ctl_oe, 0);
      chk("R1 reset ale", ale, 0);
      chk("R1 reset hold_ack", hold_ack, 0);
      chk("R1 reset req_ready", req_ready, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // main cycles
      issue(3'd0, 16'h1234, 8'h00); finish_cycle();
      issue(3'd1, 16'hBEEF, 8'h00); finish_cycle();
      issue(3'd2, 16'h4001, 8'h3C); finish_cycle();
      issue(3'd3, 16'h0087, 8'h00); finish_cycle();
      issue(3'd4, 16'h005A, 8'hC3); finish_cycle();
      issue(3'd3, 16'hFF12, 8'h00); finish_cycle();
      issue(3'd0, 16'h00FF, 8'h00); finish_cycle();
      issue(3'd2, 16'hFFFF, 8'hFF); finish_cycle();

      // R9 hold during a running fetch
      issue(3'd0, 16'h2345, 8'h00);
      hold_in = 1'b1;
      finish_cycle();
      chk("R9 hold_ack after cycle", hold_ack, 1);
      chk("R9 ad_oe floats", ad_oe, 0);
      chk("R9 ahi_oe floats", ahi_oe, 0);
      chk("R9 ctl_oe floats", ctl_oe, 0);
      chk("R9 ale low", ale, 0);
      hold_in = 1'b0;
      @(negedge clk);
      chk("R9 hold_ack released", hold_ack, 0);
      chk("R9 ready again", req_ready, 1);
      issue(3'd1, 16'h0102, 8'h00); finish_cycle();

      // R10 halt
      halt_in = 1'b1;
      @(negedge clk);
      chk("R10 halt status", stat, 0);
      chk("R10 halt ad_oe", ad_oe, 0);
      chk("R10 halt ahi_oe", ahi_oe, 0);
      chk("R10 halt ctl_oe", ctl_oe, 0);
      chk("R10 halt not ready", req_ready, 0);
      // R11 hold while halted
      hold_in = 1'b1;
      @(negedge clk);
      chk("R11 hold taken from halt", hold_ack, 1);
      hold_in = 1'b0; halt_in = 1'b0;
      @(negedge clk);
      chk("R10 leaves halt/hold", hold_ack, 0);
      chk("R10 ready after halt", req_ready, 1);

      // R11 hold wins over halt and request
      hold_in = 1'b1; halt_in = 1'b1;
      req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h7777;
      @(negedge clk);
      chk("R11 hold priority ack", hold_ack, 1);
      chk("R11 no cycle started", ale, 0);
      req_valid = 1'b0; hold_in = 1'b0; halt_in = 1'b0;
      @(negedge clk);
      issue(3'd4, 16'hAB99, 8'h11); finish_cycle();

      repeat (3) @(negedge clk);
      chk("R8 all cycles completed", exp_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule